// File: doc/BRIEF.md
# Parallel Channel Source Sequencer

This block is the sending end of a wide parallel point-to-point channel. The host raises a connect request together with a 32-bit I-field word. The sequencer asserts REQUEST with that word on the bus and waits for the far end to answer with CONNECT. While the connection is up, the host starts packets by giving a nonzero word count. The sequencer then raises PACKET. It reads the words from a show-ahead host FIFO and sends them as bursts. Each burst is followed by one check word, which is the XOR of that burst's data.

The receiver paces the bursts. Every clock cycle in which it holds READY high grants one burst credit, and each burst spends one credit. If CONNECT is lost mid-connection, the block aborts and flags an error. A self-test input takes the block off the channel: it drops the interconnect output and silences every forward line.

Top module: `hsrc_seq`

## Requirements
- R1: While reset is held and right after it, REQUEST, PACKET, BURST, `fifo_rd`, `st_conn` and `st_err` are low, and `ch_icon` is high.
- R2: After `conn_req` rises (with `st_err` low and no self-test), REQUEST goes high one cycle later. The data bus carries `ifield` until CONNECT is seen, and PACKET stays low.
- R3: A `pkt_start` pulse before CONNECT is seen, or one with `pkt_len` of zero, is ignored, and PACKET stays low.
- R4: Each cycle with READY high during a connection adds one credit. READY outside a connection is ignored, and credits are cleared when the connection ends. A burst starts only when the credit count is nonzero and `fifo_cnt` is at least the burst length. A burst start spends one credit, and a READY in the same cycle as a burst start leaves the count unchanged.
- R5: A packet of N words is sent as bursts of `BL` = 256 words. The remainder N mod 256, when nonzero, is sent as a shorter first burst.
- R6: In the cycle after a burst's last data word, BURST is low, PACKET is high, and the bus carries the XOR of all data words of that burst.
- R7: `ch_par[i]` is odd parity over bus bits 8i+7..8i, for the I-field, data and check words.
- R8: `fifo_rd` is high exactly in burst data cycles. The bus then carries the FIFO head word, so a packet of N words pops exactly N words, in order.
- R9: If CONNECT is low while connected, then in the next cycle REQUEST, PACKET and BURST are low and `st_err` is high. `st_err` stays high, with no new request, until `conn_req` is dropped, and that clears it.
- R10: While `self_test` is high, `ch_icon`, REQUEST, PACKET and BURST are low in the same cycle, and `conn_req` is ignored.
- R11: Dropping `conn_req` while connected and outside a packet lowers REQUEST and `st_conn` one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Active-low reset |
| conn_req | input | 1 | Host asks for a connection |
| ifield | input | 32 | I-field word shown during connection request |
| pkt_start | input | 1 | One-cycle pulse starting a packet |
| pkt_len | input | 16 | Packet length in words, sampled with pkt_start |
| self_test | input | 1 | Take block off the channel |
| fifo_data | input | 32 | Host FIFO head word (show-ahead) |
| fifo_cnt | input | 9 | Words available in host FIFO, saturating at 256 |
| fifo_rd | output | 1 | Pop the host FIFO |
| ch_connect | input | 1 | Reverse CONNECT |
| ch_ready | input | 1 | Reverse READY, one credit per high cycle |
| ch_req | output | 1 | Forward REQUEST |
| ch_pkt | output | 1 | Forward PACKET |
| ch_burst | output | 1 | Forward BURST |
| ch_data | output | 32 | Forward data bus |
| ch_par | output | 4 | Odd parity per byte of ch_data |
| ch_icon | output | 1 | Outgoing interconnect, low in self-test |
| st_conn | output | 1 | Connection is up |
| st_err | output | 1 | Connection was lost during transfer |

## Verification
Credit arrival and credit spending can land in the same cycle. This happens when READY is high during the cycle in which a burst leaves the gap state. To provoke it, the bench grants exactly one credit, starts a 512-word packet, and raises READY for the single cycle in which the first burst starts. If that READY is counted correctly, the credit count ends at one and the second burst proceeds without further READY. If the collision loses the grant, the packet stalls with PACKET high, and the bench detects this as missing bursts within a bounded wait.

// File: rtl/hsrc_seq.sv
module hsrc_seq #(
  parameter int DW  = 32,
  parameter int BL  = 256,
  parameter int LW  = 16,
  parameter int CRW = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       conn_req,
  input  logic [DW-1:0]              ifield,
  input  logic                       pkt_start,
  input  logic [LW-1:0]              pkt_len,
  input  logic                       self_test,
  input  logic [DW-1:0]              fifo_data,
  input  logic [$clog2(BL):0]        fifo_cnt,
  output logic                       fifo_rd,
  input  logic                       ch_connect,
  input  logic                       ch_ready,
  output logic                       ch_req,
  output logic                       ch_pkt,
  output logic                       ch_burst,
  output logic [DW-1:0]              ch_data,
  output logic [DW/8-1:0]            ch_par,
  output logic                       ch_icon,
  output logic                       st_conn,
  output logic                       st_err
);
  localparam int NB  = DW / 8;
  localparam int BLW = $clog2(BL);
  localparam int BCW = BLW + 1;

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_CONN, S_GAP, S_DATA, S_CHK} st_t;

  st_t            state;
  logic [LW-1:0]  rem;
  logic [BCW-1:0] bcnt;
  logic [CRW-1:0] credit;
  logic [DW-1:0]  llrc;
  logic           err;

  logic           live, lost, go_burst, in_pkt, on;
  logic [BCW-1:0] blen;

  assign on       = !self_test;
  assign in_pkt   = state inside {S_GAP, S_DATA, S_CHK};
  assign live     = state == S_CONN || in_pkt;
  assign lost     = live && !ch_connect;
  assign blen     = (rem[BLW-1:0] == '0) ? BCW'(BL) : {1'b0, rem[BLW-1:0]};
  assign go_burst = state == S_GAP && credit != '0 && fifo_cnt >= blen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      rem    <= '0;
      bcnt   <= '0;
      credit <= '0;
      llrc   <= '0;
      err    <= 1'b0;
    end else begin
      if (lost)
        err <= 1'b1;
      else if (state == S_IDLE && !conn_req)
        err <= 1'b0;

      if (!live || lost || self_test)
        credit <= '0;
      else if (go_burst && !ch_ready)
        credit <= credit - 1'b1;
      else if (!go_burst && ch_ready && credit != '1)
        credit <= credit + 1'b1;

      if (self_test || lost) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (conn_req && !err) state <= S_REQ;
          S_REQ: begin
            if (!conn_req)       state <= S_IDLE;
            else if (ch_connect) state <= S_CONN;
          end
          S_CONN: begin
            if (!conn_req) begin
              state <= S_IDLE;
            end else if (pkt_start && pkt_len != '0) begin
              rem   <= pkt_len;
              state <= S_GAP;
            end
          end
          S_GAP: begin
            if (go_burst) begin
              bcnt  <= blen;
              llrc  <= '0;
              state <= S_DATA;
            end
          end
          S_DATA: begin
            llrc <= llrc ^ fifo_data;
            bcnt <= bcnt - 1'b1;
            rem  <= rem - 1'b1;
            if (bcnt == BCW'(1)) state <= S_CHK;
          end
          S_CHK: state <= (rem == '0) ? S_CONN : S_GAP;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  assign ch_icon  = on;
  assign ch_req   = on && state != S_IDLE;
  assign ch_pkt   = on && in_pkt;
  assign ch_burst = on && state == S_DATA;
  assign fifo_rd  = ch_burst;
  assign st_conn  = live;
  assign st_err   = err;

  always_comb begin
    ch_data = '0;
    if (on) begin
      case (state)
        S_REQ:   ch_data = ifield;
        S_DATA:  ch_data = fifo_data;
        S_CHK:   ch_data = llrc;
        default: ch_data = '0;
      endcase
    end
  end

  for (genvar i = 0; i < NB; i++) begin : g_par
    assign ch_par[i] = ~^ch_data[8*i +: 8];
  end
endmodule

module hsrc_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic self_test,
  input logic ch_connect,
  input logic ch_req,
  input logic ch_pkt,
  input logic ch_burst,
  input logic ch_icon,
  input logic fifo_rd,
  input logic st_err
);
  AST_BURST_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    ch_burst |-> (ch_pkt && ch_req)); // R6
  AST_READ_ONLY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> ch_burst); // R8
  AST_SELFTEST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    self_test |-> (!ch_icon && !ch_req && !ch_pkt)); // R10
  AST_ABORT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_pkt && !ch_connect) |=> (!ch_req && !ch_pkt && st_err)); // R9
  AST_ERR_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    st_err |-> (!ch_req && !ch_pkt)); // R9
  AST_CHECK_WORD_IN_PACKET: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ch_burst) && $past(ch_connect) && !$past(self_test) && !self_test) |-> ch_pkt); // R6
endmodule

bind hsrc_seq hsrc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .self_test(self_test), .ch_connect(ch_connect),
  .ch_req(ch_req), .ch_pkt(ch_pkt), .ch_burst(ch_burst), .ch_icon(ch_icon),
  .fifo_rd(fifo_rd), .st_err(st_err)
);

// File: tb/hsrc_seq_tb.sv
module hsrc_seq_tb;
  localparam int BL = 256;
  localparam int NV = 5;
  // {packet length, expected bursts, expected first burst length}
  localparam int VEC [NV][3] = '{'{1, 1, 1}, '{5, 1, 5}, '{256, 1, 256},
                                 '{300, 2, 44}, '{600, 3, 88}};

  logic clk = 0, rst_n = 0;
  logic conn_req = 0, pkt_start = 0, self_test = 0, ch_connect = 0, ch_ready = 0;
  logic [31:0] ifield = 0;
  logic [15:0] pkt_len = 0;
  logic [31:0] fifo_data;
  logic [8:0]  fifo_cnt;
  logic fifo_rd, ch_req, ch_pkt, ch_burst, ch_icon, st_conn, st_err;
  logic [31:0] ch_data;
  logic [3:0]  ch_par;

  int errs = 0, checks = 0;
  int rp = 0, wp = 0;
  int nb_seen = 0, dat_bad = 0, llrc_bad = 0, par_bad = 0;
  int bl_log [64];
  int cur_len = 0;
  logic [31:0] acc = 0;
  logic prev_burst = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [31:0] word(int i);
    return 32'hA5C3_0000 ^ (i * 32'h0100_0193) ^ (i << 20);
  endfunction

  function automatic logic [3:0] oddp(logic [31:0] d);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = ~^d[8*b +: 8];
    return p;
  endfunction

  assign fifo_data = word(rp);
  assign fifo_cnt  = (wp - rp > BL) ? 9'(BL) : 9'(wp - rp);

  hsrc_seq u_dut (
    .clk(clk), .rst_n(rst_n), .conn_req(conn_req), .ifield(ifield),
    .pkt_start(pkt_start), .pkt_len(pkt_len), .self_test(self_test),
    .fifo_data(fifo_data), .fifo_cnt(fifo_cnt), .fifo_rd(fifo_rd),
    .ch_connect(ch_connect), .ch_ready(ch_ready), .ch_req(ch_req),
    .ch_pkt(ch_pkt), .ch_burst(ch_burst), .ch_data(ch_data), .ch_par(ch_par),
    .ch_icon(ch_icon), .st_conn(st_conn), .st_err(st_err)
  );

  always @(posedge clk) if (fifo_rd) rp <= rp + 1;

  always @(negedge clk) begin
    if (ch_req && ch_par !== oddp(ch_data)) par_bad <= par_bad + 1;
    if (ch_burst) begin
      if (ch_data !== word(rp)) dat_bad <= dat_bad + 1;
      acc <= acc ^ ch_data;
      cur_len <= cur_len + 1;
    end else if (prev_burst) begin
      if (ch_pkt) begin
        if (ch_data !== acc) llrc_bad <= llrc_bad + 1;
        bl_log[nb_seen % 64] <= cur_len;
        nb_seen <= nb_seen + 1;
      end
      acc <= 0;
      cur_len <= 0;
    end
    prev_burst <= ch_burst;
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic give_credits(int n);
    ch_ready = 1;
    cyc(n);
    ch_ready = 0;
  endtask

  task automatic pulse_pkt(int len);
    pkt_len = 16'(len);
    pkt_start = 1;
    cyc(1);
    pkt_start = 0;
  endtask

  task automatic wait_pkt_end(output bit ok);
    bit seen = 0;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (ch_pkt) seen = 1;
      else if (seen) begin ok = 1; break; end
    end
    @(posedge clk); #2;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit ok;
    int s_nb, s_rp, s_d, s_l, s_p;
    cyc(3);
    @(negedge clk);
    chk(!ch_req && !ch_pkt && !ch_burst && !fifo_rd && ch_icon && !st_err && !st_conn,
        "R1 reset outputs", {ch_req, ch_pkt, ch_burst, fifo_rd, ch_icon, st_err}, 6'b000010);
    @(posedge clk); #2 rst_n = 1;
    cyc(1);
    chk(!ch_req && ch_icon, "R1 after reset", {ch_req, ch_icon}, 2'b01);

    // R2 request with I-field
    ifield = 32'h1234_5A0F; conn_req = 1;
    cyc(1);
    @(negedge clk);
    chk(ch_req && ch_data == ifield && !ch_pkt, "R2 request shows I-field", ch_data, ifield);
    chk(ch_par == oddp(ifield), "R7 I-field parity", ch_par, oddp(ifield));

    // R3 packet start before connect ignored; R4 ready ignored outside connection
    wp = rp + 4;
    pulse_pkt(4);
    give_credits(3);
    cyc(2);
    chk(!ch_pkt, "R3 packet before connect", ch_pkt, 0);
    ch_connect = 1;
    cyc(3);
    chk(st_conn && !ch_pkt, "R3 connected, stale start ignored", {st_conn, ch_pkt}, 2'b10);
    pulse_pkt(0);
    cyc(3);
    chk(!ch_pkt, "R3 zero-length start ignored", ch_pkt, 0);

    // R4 no burst without credit
    s_nb = nb_seen;
    pulse_pkt(4);
    cyc(10);
    chk(ch_pkt && !ch_burst, "R4 held without credit", {ch_pkt, ch_burst}, 2'b10);
    give_credits(1);
    wait_pkt_end(ok);
    chk(ok && nb_seen == s_nb + 1 && bl_log[s_nb % 64] == 4, "R4 burst after one credit",
        bl_log[s_nb % 64], 4);

    // R4 no burst while FIFO short
    s_nb = nb_seen;
    give_credits(1);
    wp = rp + 3;
    pulse_pkt(8);
    cyc(10);
    chk(ch_pkt && !ch_burst, "R4 held on short FIFO", {ch_pkt, ch_burst}, 2'b10);
    wp = rp + 8;
    wait_pkt_end(ok);
    chk(ok && bl_log[s_nb % 64] == 8, "R4 burst after FIFO fill", bl_log[s_nb % 64], 8);

    // vector table: R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      s_nb = nb_seen; s_rp = rp; s_d = dat_bad; s_l = llrc_bad; s_p = par_bad;
      give_credits(VEC[v][1]);
      wp = rp + VEC[v][0];
      pulse_pkt(VEC[v][0]);
      wait_pkt_end(ok);
      chk(ok && nb_seen - s_nb == VEC[v][1], "R5 burst count", nb_seen - s_nb, VEC[v][1]);
      chk(bl_log[s_nb % 64] == VEC[v][2], "R5 first burst length", bl_log[s_nb % 64], VEC[v][2]);
      for (int b = 1; b < VEC[v][1]; b++)
        chk(bl_log[(s_nb + b) % 64] == BL, "R5 full burst length", bl_log[(s_nb + b) % 64], BL);
      chk(llrc_bad == s_l, "R6 check word", llrc_bad - s_l, 0);
      chk(par_bad == s_p, "R7 parity", par_bad - s_p, 0);
      chk(dat_bad == s_d && rp - s_rp == VEC[v][0], "R8 words popped in order",
          rp - s_rp, VEC[v][0]);
    end

    // R4 credit grant and spend in the same cycle
    s_nb = nb_seen;
    give_credits(1);
    wp = rp + 512;
    pkt_len = 16'd512; pkt_start = 1;
    cyc(1);
    pkt_start = 0; ch_ready = 1;
    cyc(1);
    ch_ready = 0;
    wait_pkt_end(ok);
    chk(ok && nb_seen - s_nb == 2, "R4 simultaneous ready and burst start", nb_seen - s_nb, 2);

    // R11 release connection
    conn_req = 0;
    cyc(1);
    @(negedge clk);
    chk(!ch_req && !st_conn, "R11 request drops", {ch_req, st_conn}, 0);

    // R9 abort on lost connect
    conn_req = 1;
    cyc(4);
    give_credits(1);
    wp = rp + 256;
    pulse_pkt(256);
    cyc(6);
    chk(ch_burst, "R9 burst in progress", ch_burst, 1);
    ch_connect = 0;
    cyc(1);
    @(negedge clk);
    chk(!ch_req && !ch_pkt && !ch_burst && st_err, "R9 abort",
        {ch_req, ch_pkt, ch_burst, st_err}, 4'b0001);
    cyc(3);
    chk(!ch_req && st_err, "R9 error holds off request", {ch_req, st_err}, 2'b01);
    conn_req = 0;
    cyc(1);
    chk(!st_err, "R9 error cleared by release", st_err, 0);
    wp = rp;

    // R10 self-test
    ch_connect = 1; conn_req = 1;
    cyc(3);
    chk(st_conn, "R10 setup connected", st_conn, 1);
    @(posedge clk); #2 self_test = 1;
    @(negedge clk);
    chk(!ch_icon && !ch_req && !ch_pkt && !ch_burst, "R10 off channel",
        {ch_icon, ch_req, ch_pkt, ch_burst}, 0);
    cyc(5);
    chk(!ch_req && !st_conn && !st_err, "R10 request ignored", {ch_req, st_conn, st_err}, 0);
    self_test = 0;
    cyc(2);
    chk(ch_icon && ch_req, "R10 back on channel", {ch_icon, ch_req}, 2'b11);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule